// File: doc/BRIEF.md
# Relocatable Register Window Decoder

This block watches every bus cycle and decides whether it targets a 256-byte window of internal peripheral registers. The window's base can be moved while the system runs. Its location is held in a 16-bit relocation register, and that register sits inside the very window it positions, at byte offset 0xFE.

When a cycle lands in the window, the block flags an internal hit and hands the peripherals an 8-bit register offset. The outside strobes, status and address still run as they would for any normal cycle, so the block does not block them. It does raise two enables that tell the bus interface to ignore external read data and both external ready inputs for the whole cycle.

The relocation register has three jobs:
- It gives the upper twelve address bits of the window base.
- It chooses whether the window lives in memory space or in I/O space.
- It carries two control bits that are exported to other units: an interrupt-controller slave-mode flag and a trap-on-escape-opcode enable.

Top module: `reloc_window_decoder`

## Requirements
- R1: After reset the relocation value is 0x00FF. The window is therefore in I/O space at base 0xFF00, and the slave-mode and escape-trap outputs are both low.
- R2: `win_hit` is high only when all three of these hold: (a) `rd_stb` or `wr_stb` is high; (b) `bus_addr[19:8]` equals relocation bits 11:0; (c) the cycle type matches relocation bit 12. For (c), bit 12 = 1 selects memory space (`io_cycle` = 0) and bit 12 = 0 selects I/O space (`io_cycle` = 1).
- R3: `win_ofs` equals `bus_addr[7:0]` while `win_hit` is high, and is zero otherwise.
- R4: `ext_ready_ignore` equals `win_hit`. `ext_data_ignore` is high only on a hit read cycle.
- R5: Only a write that hits the window at offset 0xFE loads all 16 bits of `wr_data` into the relocation register. Three kinds of write leave it unchanged: writes to other offsets, writes in the wrong space, and writes outside the window.
- R6: A new relocation value has no effect during the strobe that writes it; decoding keeps the old base. The value appears on `reloc_value` after the first clock edge at which both strobes are low, and the next bus cycle decodes against it.
- R7: `intc_slave` follows relocation bit 14 and `esc_trap_en` follows relocation bit 13.
- R8: A read of offset 0xFE does not change the relocation register.
- R9: The low eight address bits do not affect the match, so offsets 0x00 and 0xFF both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Cycle address |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| win_hit | output | 1 | Cycle targets the register window |
| win_ofs | output | 8 | Register offset inside the window |
| ext_data_ignore | output | 1 | Discard external read data |
| ext_ready_ignore | output | 1 | Discard external ready inputs |
| reloc_value | output | 16 | Relocation register contents |
| intc_slave | output | 1 | Interrupt controller slave-mode flag |
| esc_trap_en | output | 1 | Trap-on-escape-opcode enable |

## Verification
Each kind of internal fault shows at the ports in a predictable way, and usually quickly:
- A corrupt relocation register appears on `reloc_value` one cycle after the bad load.
- A corrupt base also shows on the next bus cycle as a window hit that is missing or spurious.
- A pending write that is applied too early moves the base in the middle of a strobe. The second cycle of a held write then loses its hit.
- A write that is never applied leaves the old base visible after the idle cycle.

The bench probes each window edge, both spaces, and a base move followed by decoding at the new and the old location.

// File: rtl/reloc_win_pkg.sv
package reloc_win_pkg;

  // decode outcome for one bus cycle
  typedef struct packed {
    logic       hit;
    logic [7:0] ofs;
    logic       ign_data;
    logic       ign_ready;
  } win_dec_t;

endpackage

// File: rtl/rwd_rst_sync.sv
module rwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/rwd_match.sv
module rwd_match #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned WIN_W  = 8,
  localparam int unsigned BASE_W = ADDR_W - WIN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_cyc,
  input  logic              rd,
  input  logic              wr,
  input  logic [BASE_W-1:0] base,
  input  logic              mem_space,
  output logic              hit,
  output logic [WIN_W-1:0]  ofs,
  output logic              ign_data,
  output logic              ign_ready
);

  logic base_eq;
  logic space_eq;
  logic strobe;

  always_comb begin
    strobe    = rd | wr;
    base_eq   = (addr[ADDR_W-1:WIN_W] == base);
    space_eq  = (io_cyc != mem_space);
    hit       = strobe & base_eq & space_eq;
    ofs       = hit ? addr[WIN_W-1:0] : '0;
    ign_ready = hit;
    ign_data  = hit & rd;
  end

endmodule

// File: rtl/rwd_reloc_reg.sv
module rwd_reloc_reg #(
  parameter int unsigned    DATA_W    = 16,
  parameter int unsigned    WIN_W     = 8,
  parameter int unsigned    REG_OFS   = 254,
  parameter logic [15:0]    RESET_VAL = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr,
  input  logic              busy,
  input  logic [WIN_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reloc_q
);

  localparam logic [WIN_W-1:0] OFS_SEL = WIN_W'(REG_OFS);

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [DATA_W-1:0] reloc_d;
  logic              load_en;
  logic              cap_en;

  // next state: capture on a hitting write, commit once the bus is idle
  always_comb begin
    pend_d   = pend_q;
    shadow_d = shadow_q;
    reloc_d  = reloc_q;
    load_en  = 1'b0;
    cap_en   = 1'b0;
    if (pend_q && !busy) begin
      reloc_d = shadow_q;
      load_en = 1'b1;
      pend_d  = 1'b0;
    end
    if (hit && wr && (ofs == OFS_SEL)) begin
      shadow_d = wdata;
      cap_en   = 1'b1;
      pend_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_q  <= DATA_W'(RESET_VAL);
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (cap_en)  shadow_q <= shadow_d;
      if (load_en) reloc_q  <= reloc_d;
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reloc_q)); // R6

  AST_HOLD_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(reloc_q)); // R5

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reloc_q == DATA_W'(RESET_VAL))); // R1

endmodule

// File: rtl/reloc_window_decoder.sv
module reloc_window_decoder #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned WIN_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_OFS   = 254,
  parameter logic [15:0] RESET_VAL = 16'h00FF,
  parameter int unsigned SPACE_BIT = 12,
  parameter int unsigned ESC_BIT   = 13,
  parameter int unsigned SLAVE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              io_cycle,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              win_hit,
  output logic [WIN_W-1:0]  win_ofs,
  output logic              ext_data_ignore,
  output logic              ext_ready_ignore,
  output logic [DATA_W-1:0] reloc_value,
  output logic              intc_slave,
  output logic              esc_trap_en
);

  import reloc_win_pkg::*;

  localparam int unsigned BASE_W = ADDR_W - WIN_W;

  logic              rst_n_s;
  logic [DATA_W-1:0] reloc_q;
  win_dec_t          dec;
  logic              hit_w, ign_d_w, ign_r_w;
  logic [WIN_W-1:0]  ofs_w;
  logic              busy;

  rwd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  rwd_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
    .addr      (bus_addr),
    .io_cyc    (io_cycle),
    .rd        (rd_stb),
    .wr        (wr_stb),
    .base      (reloc_q[BASE_W-1:0]),
    .mem_space (reloc_q[SPACE_BIT]),
    .hit       (hit_w),
    .ofs       (ofs_w),
    .ign_data  (ign_d_w),
    .ign_ready (ign_r_w)
  );

  assign busy = rd_stb | wr_stb;

  rwd_reloc_reg #(
    .DATA_W(DATA_W), .WIN_W(WIN_W), .REG_OFS(REG_OFS), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .hit     (hit_w),
    .wr      (wr_stb),
    .busy    (busy),
    .ofs     (ofs_w),
    .wdata   (wr_data),
    .reloc_q (reloc_q)
  );

  always_comb begin
    dec.hit       = hit_w;
    dec.ofs       = 8'(ofs_w);
    dec.ign_data  = ign_d_w;
    dec.ign_ready = ign_r_w;
  end

  assign win_hit          = dec.hit;
  assign win_ofs          = WIN_W'(dec.ofs);
  assign ext_data_ignore  = dec.ign_data;
  assign ext_ready_ignore = dec.ign_ready;
  assign reloc_value      = reloc_q;
  assign intc_slave       = reloc_q[SLAVE_BIT];
  assign esc_trap_en      = reloc_q[ESC_BIT];

  AST_HIT_BASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_hit |-> (bus_addr[ADDR_W-1:WIN_W] == reloc_value[BASE_W-1:0])); // R2

  AST_OFS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    !win_hit |-> (win_ofs == '0)); // R3

  AST_DATA_IGN_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    ext_data_ignore |-> (rd_stb && ext_ready_ignore)); // R4

endmodule

// File: tb/reloc_window_decoder_test.sv
`timescale 1ns/100ps
module reloc_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] bus_addr;
  logic        io_cycle, rd_stb, wr_stb;
  logic [15:0] wr_data;
  logic        win_hit, ext_data_ignore, ext_ready_ignore, intc_slave, esc_trap_en;
  logic [7:0]  win_ofs;
  logic [15:0] reloc_value;

  always #2.5 clk = ~clk;

  reloc_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .io_cycle(io_cycle),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .win_hit(win_hit), .win_ofs(win_ofs), .ext_data_ignore(ext_data_ignore),
    .ext_ready_ignore(ext_ready_ignore), .reloc_value(reloc_value),
    .intc_slave(intc_slave), .esc_trap_en(esc_trap_en)
  );

  typedef struct {
    logic        hit;
    logic [7:0]  ofs;
    logic        ignd;
    logic        ignr;
    logic [15:0] reloc;
    logic        slv;
    logic        esc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad   = 0;
  logic [15:0] m_reloc;
  logic [15:0] m_shadow;
  bit          m_pend;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle, push the expected outputs, advance the model
  task automatic step(input logic io, input logic rd, input logic wr,
                      input logic [19:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    logic stb, hit;
    @(negedge clk);
    io_cycle = io; rd_stb = rd; wr_stb = wr; bus_addr = a; wr_data = d;
    #1;
    stb   = rd | wr;
    hit   = stb && (a[19:8] == m_reloc[11:0]) && (io == !m_reloc[12]);
    e.hit = hit;
    e.ofs = hit ? a[7:0] : 8'h00;
    e.ignd = hit & rd;
    e.ignr = hit;
    e.reloc = m_reloc;
    e.slv = m_reloc[14];
    e.esc = m_reloc[13];
    e.tag = tag;
    sb.push_back(e);
    if (m_pend && !stb) begin
      m_reloc = m_shadow;
      m_pend  = 1'b0;
    end
    if (hit && wr && a[7:0] == 8'hFE) begin
      m_shadow = d;
      m_pend   = 1'b1;
    end
  endtask

  // monitor: pop and compare after the driver has settled the cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "hit",   16'(win_hit),          16'(e.hit));
        chk(e.tag, "ofs",   16'(win_ofs),          16'(e.ofs));
        chk(e.tag, "ignd",  16'(ext_data_ignore),  16'(e.ignd));
        chk(e.tag, "ignr",  16'(ext_ready_ignore), 16'(e.ignr));
        chk(e.tag, "reloc", reloc_value,           e.reloc);
        chk(e.tag, "slave", 16'(intc_slave),       16'(e.slv));
        chk(e.tag, "esc",   16'(esc_trap_en),      16'(e.esc));
      end
    end
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; io_cycle = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    m_reloc = 16'h00FF; m_shadow = '0; m_pend = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R1_reset");
    step(1'b1, 1'b1, 1'b0, 20'h0FF10, 16'h0, "R2_R3_R4_io_read_hit");
    step(1'b1, 1'b0, 1'b0, 20'h0FF10, 16'h0, "R2_no_strobe");
    step(1'b0, 1'b1, 1'b0, 20'h0FF10, 16'h0, "R2_wrong_space");
    step(1'b1, 1'b1, 1'b0, 20'h0FE10, 16'h0, "R2_base_miss");
    step(1'b1, 1'b1, 1'b0, 20'h0FF00, 16'h0, "R9_low_edge");
    step(1'b1, 1'b0, 1'b1, 20'h0FFFF, 16'h0, "R9_R4_high_edge_write");
    step(1'b1, 1'b0, 1'b1, 20'h0FF20, 16'h1234, "R5_other_offset");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R5_idle");
    step(1'b0, 1'b0, 1'b1, 20'h0FFFE, 16'h5555, "R5_wrong_space_write");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R5_idle2");
    step(1'b1, 1'b1, 1'b0, 20'h0FFFE, 16'h0, "R8_read_reg");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R8_idle");
    step(1'b1, 1'b0, 1'b1, 20'h0FFFE, 16'h7123, "R6_write_first");
    step(1'b1, 1'b0, 1'b1, 20'h0FFFE, 16'h7123, "R6_write_held_old_base");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R6_idle_commit");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R6_R7_new_value");
    step(1'b0, 1'b1, 1'b0, 20'h12345, 16'h0, "R2_R6_new_base_mem");
    step(1'b1, 1'b1, 1'b0, 20'h12345, 16'h0, "R2_new_space_io_miss");
    step(1'b1, 1'b1, 1'b0, 20'h0FF10, 16'h0, "R6_old_base_gone");
    step(1'b0, 1'b0, 1'b1, 20'h123FE, 16'h00AB, "R5_write_back_io");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R7_idle");
    step(1'b0, 1'b0, 1'b0, 20'h00000, 16'h0, "R7_bits_cleared");
    step(1'b1, 1'b1, 1'b0, 20'h0AB80, 16'h0, "R2_R3_io_base_ab");
    step(1'b1, 1'b0, 1'b0, 20'h00000, 16'h0, "R3_idle_ofs_zero");

    repeat (3) @(negedge clk);
    #2.2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule